// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block sequences one conversion of a successive-approximation ADC. A 3-bit source select chooses what starts a conversion: a pulse from one of three timers, a rising or falling edge on an external convert pin, a software start strobe, or free-running continuous operation. Once a trigger is accepted, the sequencer raises the track/hold control for a track interval that depends on whether the converter powers down between conversions and on whether the front-end amplifier runs at unity gain. It then runs a fixed SAR phase and finishes with a one-cycle done pulse.

Busy covers the whole span from the accepted trigger to the end of the SAR phase, and triggers that arrive during that span are dropped. In continuous mode the sequencer chains conversions back to back on a fixed period until the source select moves away from the continuous code. Setting the dual-mode control stops any new conversion from starting, because only the single-edge behaviour is implemented here.

States: `ST_IDLE` (waiting), `ST_TRACK` (track/hold tracking), `ST_CONVERT` (SAR phase). Transitions: `ST_IDLE`→`ST_TRACK` on an accepted trigger; `ST_TRACK`→`ST_CONVERT` when the track count runs out; `ST_CONVERT`→`ST_TRACK` at the end of the SAR phase when continuous mode is still selected; `ST_CONVERT`→`ST_IDLE` at the end of the SAR phase otherwise.

Top module: `adc_conv_sequencer`

## Requirements
- R1: While reset is held and right after its release, track_hold, sar_active, busy, done and start_flag are all 0.
- R2: Source codes: 000, 001 and 010 start on a one-cycle pulse of timer event bit 0, 1 and 2 respectively; 111 starts on start_wr. Code 011 never starts a conversion, and an event that does not belong to the selected code starts nothing.
- R3: Code 100 starts on a rising edge and code 101 on a falling edge of cnv_pin, after a two-flop synchronizer; track_hold is first seen high after the third rising clock edge following the pin change. A timer pulse or start_wr is seen as track_hold high after the first rising edge.
- R4: Track interval (cycles with track_hold = 1): 13 with auto_shdn = 1 and gain_unity = 1, 93 with auto_shdn = 1 and gain_unity = 0, 3 with auto_shdn = 0 and gain_unity = 1, 43 with auto_shdn = 0 and gain_unity = 0.
- R5: sar_active is 1 for exactly 13 cycles, starting in the first cycle after track_hold falls.
- R6: done is 1 for exactly one cycle, the first cycle after sar_active falls; outside continuous mode busy is 0 in that same cycle.
- R7: busy is 1 from the first track cycle through the last SAR cycle, and a trigger arriving while busy is 1 has no effect.
- R8: For code 111, start_flag is 1 while the conversion it started is busy and is 0 from the done cycle on.
- R9: With code 110 a conversion starts with no trigger event and repeats every 16 cycles when gain_unity = 1 and every 56 cycles when gain_unity = 0; the track interval is 3 or 43 cycles whatever auto_shdn is, and done and the next track cycle coincide.
- R10: Moving the source select off 110 lets the conversion in progress finish and then no further conversion starts.
- R11: While dual_mode = 1 no conversion starts, including a continuous restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 3 | Conversion source select |
| dual_mode | input | 1 | Dual-mode control; 1 blocks new conversions |
| auto_shdn | input | 1 | Converter powers down between conversions |
| gain_unity | input | 1 | Amplifier gain is 1 |
| tmr_evt | input | 3 | One-cycle timer event pulses, bit i for timer i |
| cnv_pin | input | 1 | Asynchronous external convert pin |
| start_wr | input | 1 | Software start strobe |
| track_hold | output | 1 | 1 = track, 0 = hold |
| sar_active | output | 1 | SAR phase in progress |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse at conversion end |
| start_flag | output | 1 | Software start bit readback |

## Verification
In continuous mode the done pulse of one conversion and the first track cycle of the next fall in the same cycle, because the SAR end hands straight back to `ST_TRACK`. The bench runs continuous mode at both gains, looks for a cycle where done and track_hold are both 1, and measures the distance between successive track starts against 16 and 56 cycles. The second collision is a change of source select arriving during a running continuous conversion; it must take effect only at that conversion's end, which the bench judges by a finished conversion followed by a quiet stretch of idle cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TRACK   = 2'd1,
        ST_CONVERT = 2'd2
    } seq_state_e;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SRC_RESERVED = 3'b011;
    localparam logic [SEL_W-1:0] SRC_PIN_RISE = 3'b100;
    localparam logic [SEL_W-1:0] SRC_PIN_FALL = 3'b101;
    localparam logic [SEL_W-1:0] SRC_CONT     = 3'b110;
    localparam logic [SEL_W-1:0] SRC_SOFT     = 3'b111;

endpackage

// File: rtl/adc_pin_edge.sv
module adc_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    // stages 0..SYNC_STAGES-1 synchronize, the last one keeps the previous value
    logic [SYNC_STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-1:0], pin};
        end
    end

    assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    assign fall = ~chain_q[SYNC_STAGES-1] & chain_q[SYNC_STAGES];

endmodule

// File: rtl/adc_trig_select.sv
module adc_trig_select
    import adc_seq_pkg::*;
#(
    parameter int NUM_TMR = 3
) (
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [NUM_TMR-1:0] tmr_evt,
    input  logic               pin_rise,
    input  logic               pin_fall,
    input  logic               start_wr,
    output logic               trig,
    output logic               cont_sel,
    output logic               soft_sel
);
    logic [NUM_TMR-1:0] tmr_hit;

    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
        assign tmr_hit[gi] = (src_sel == SEL_W'(gi)) && tmr_evt[gi];
    end

    assign cont_sel = (src_sel == SRC_CONT);
    assign soft_sel = (src_sel == SRC_SOFT);

    always_comb begin
        trig = |tmr_hit;
        unique case (src_sel)
            SRC_PIN_RISE: trig = pin_rise;
            SRC_PIN_FALL: trig = pin_fall;
            SRC_CONT:     trig = 1'b1;
            SRC_SOFT:     trig = start_wr;
            default:      ;
        endcase
    end

endmodule

// File: rtl/adc_track_len.sv
module adc_track_len #(
    parameter int TRK_SHDN_UNITY = 13,
    parameter int TRK_SHDN_GAIN  = 93,
    parameter int TRK_ON_UNITY   = 3,
    parameter int TRK_ON_GAIN    = 43,
    parameter int CNT_W          = 7
) (
    input  logic             auto_shdn,
    input  logic             gain_unity,
    input  logic             cont_mode,
    output logic [CNT_W-1:0] load_val
);
    // continuous mode never pays the power-up share
    logic powered_down;

    assign powered_down = auto_shdn && !cont_mode;

    always_comb begin
        unique case ({powered_down, gain_unity})
            2'b11:   load_val = CNT_W'(TRK_SHDN_UNITY - 1);
            2'b10:   load_val = CNT_W'(TRK_SHDN_GAIN - 1);
            2'b01:   load_val = CNT_W'(TRK_ON_UNITY - 1);
            default: load_val = CNT_W'(TRK_ON_GAIN - 1);
        endcase
    end

endmodule

// File: rtl/adc_phase_counter.sv
module adc_phase_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             cnt_zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
    import adc_seq_pkg::*;
#(
    parameter int NUM_TMR        = 3,
    parameter int SYNC_STAGES    = 2,
    parameter int TRK_SHDN_UNITY = 13,
    parameter int TRK_SHDN_GAIN  = 93,
    parameter int TRK_ON_UNITY   = 3,
    parameter int TRK_ON_GAIN    = 43,
    parameter int SAR_CYCLES     = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         src_sel,
    input  logic               dual_mode,
    input  logic               auto_shdn,
    input  logic               gain_unity,
    input  logic [NUM_TMR-1:0] tmr_evt,
    input  logic               cnv_pin,
    input  logic               start_wr,
    output logic               track_hold,
    output logic               sar_active,
    output logic               busy,
    output logic               done,
    output logic               start_flag
);
    localparam int MAX_A   = (TRK_SHDN_UNITY > TRK_SHDN_GAIN) ? TRK_SHDN_UNITY : TRK_SHDN_GAIN;
    localparam int MAX_B   = (TRK_ON_UNITY > TRK_ON_GAIN) ? TRK_ON_UNITY : TRK_ON_GAIN;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_LEN = (MAX_C > SAR_CYCLES) ? MAX_C : SAR_CYCLES;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    seq_state_e       state_q, state_d;
    logic             pin_rise, pin_fall;
    logic             trig, cont_sel, soft_sel, accept;
    logic [CNT_W-1:0] track_val, cnt_load_val;
    logic             cnt_load, cnt_zero;
    logic             done_q, soft_q;
    logic             sar_end;

    adc_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (cnv_pin),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    adc_trig_select #(.NUM_TMR(NUM_TMR)) u_trig_select (
        .src_sel (src_sel),
        .tmr_evt (tmr_evt),
        .pin_rise(pin_rise),
        .pin_fall(pin_fall),
        .start_wr(start_wr),
        .trig    (trig),
        .cont_sel(cont_sel),
        .soft_sel(soft_sel)
    );

    adc_track_len #(
        .TRK_SHDN_UNITY(TRK_SHDN_UNITY),
        .TRK_SHDN_GAIN (TRK_SHDN_GAIN),
        .TRK_ON_UNITY  (TRK_ON_UNITY),
        .TRK_ON_GAIN   (TRK_ON_GAIN),
        .CNT_W         (CNT_W)
    ) u_track_len (
        .auto_shdn (auto_shdn),
        .gain_unity(gain_unity),
        .cont_mode (cont_sel),
        .load_val  (track_val)
    );

    adc_phase_counter #(.CNT_W(CNT_W)) u_phase_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_load_val),
        .cnt_zero(cnt_zero)
    );

    assign accept  = trig && !dual_mode;
    assign sar_end = (state_q == ST_CONVERT) && cnt_zero;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and counter load
    always_comb begin
        state_d      = state_q;
        cnt_load     = 1'b0;
        cnt_load_val = track_val;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d  = ST_TRACK;
                    cnt_load = 1'b1;
                end
            end
            ST_TRACK: begin
                if (cnt_zero) begin
                    state_d      = ST_CONVERT;
                    cnt_load     = 1'b1;
                    cnt_load_val = CNT_W'(SAR_CYCLES - 1);
                end
            end
            ST_CONVERT: begin
                if (cnt_zero) begin
                    if (cont_sel && !dual_mode) begin
                        state_d  = ST_TRACK;
                        cnt_load = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // done pulse and software start bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            soft_q <= 1'b0;
        end else begin
            done_q <= sar_end;
            if (sar_end) begin
                soft_q <= 1'b0;
            end else if (state_q == ST_IDLE && accept && soft_sel) begin
                soft_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        track_hold = 1'b0;
        sar_active = 1'b0;
        busy       = 1'b0;
        unique case (state_q)
            ST_TRACK: begin
                track_hold = 1'b1;
                busy       = 1'b1;
            end
            ST_CONVERT: begin
                sar_active = 1'b1;
                busy       = 1'b1;
            end
            default: ;
        endcase
        done       = done_q;
        start_flag = soft_q;
    end

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int SAR_CYCLES = 13
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] src_sel,
    input logic       dual_mode,
    input logic       track_hold,
    input logic       sar_active,
    input logic       busy,
    input logic       done,
    input logic       start_flag
);
    localparam int RUN_W = $clog2(SAR_CYCLES + 2);

    logic [RUN_W-1:0] sar_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_run_q <= '0;
        end else if (sar_active) begin
            sar_run_q <= sar_run_q + 1'b1;
        end else begin
            sar_run_q <= '0;
        end
    end

    a_r5_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({track_hold, sar_active}));

    a_r5_sar_after_track: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(track_hold) |-> sar_active);

    a_r5_sar_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sar_active) |-> (sar_run_q == RUN_W'(SAR_CYCLES)));

    a_r6_done_after_sar: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(sar_active) && !sar_active));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && src_sel == 3'b011) |=> !busy);

    a_r11_dual_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && dual_mode) |=> !busy);

    a_r8_flag_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_flag |-> busy);

endmodule

bind adc_conv_sequencer adc_seq_checker #(.SAR_CYCLES(SAR_CYCLES)) u_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sel   (src_sel),
    .dual_mode (dual_mode),
    .track_hold(track_hold),
    .sar_active(sar_active),
    .busy      (busy),
    .done      (done),
    .start_flag(start_flag)
);

// File: tb/test_adc_conv_sequencer.sv
module test_adc_conv_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_sel = 3'b011;
    logic       dual_mode = 1'b0;
    logic       auto_shdn = 1'b0;
    logic       gain_unity = 1'b1;
    logic [2:0] tmr_evt = 3'b000;
    logic       cnv_pin = 1'b0;
    logic       start_wr = 1'b0;
    logic       track_hold, sar_active, busy, done, start_flag;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_conv_sequencer i_adc_conv_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel   (src_sel),
        .dual_mode (dual_mode),
        .auto_shdn (auto_shdn),
        .gain_unity(gain_unity),
        .tmr_evt   (tmr_evt),
        .cnv_pin   (cnv_pin),
        .start_wr  (start_wr),
        .track_hold(track_hold),
        .sar_active(sar_active),
        .busy      (busy),
        .done      (done),
        .start_flag(start_flag)
    );

    // vectors: source, auto_shdn, gain_unity, expected latency, expected track length
    localparam int VEC_N = 9;
    localparam int V_SRC [VEC_N] = '{0, 1, 2, 4, 5, 7, 7, 0, 5};
    localparam int V_SHDN[VEC_N] = '{0, 1, 1, 0, 1, 0, 1, 1, 0};
    localparam int V_GAIN[VEC_N] = '{1, 1, 0, 0, 1, 0, 0, 0, 1};
    localparam int V_LAT [VEC_N] = '{1, 1, 1, 3, 3, 1, 1, 1, 3};
    localparam int V_TRK [VEC_N] = '{3, 13, 93, 43, 13, 43, 93, 93, 3};

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // watches busy for n cycles and returns how many were high
    task automatic count_busy(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy) hi++;
        end
    endtask

    task automatic run_conv(input int src, input int shdn, input int gain,
                            input int exp_lat, input int exp_trk);
        int lat, trk, sar;
        src_sel    = 3'b011;
        auto_shdn  = shdn[0];
        gain_unity = gain[0];
        cnv_pin    = (src == 5);
        idle_cycles(5);
        src_sel = 3'(src);
        @(negedge clk);
        case (src)
            0, 1, 2: tmr_evt[src] = 1'b1;
            4:       cnv_pin = 1'b1;
            5:       cnv_pin = 1'b0;
            default: start_wr = 1'b1;
        endcase
        lat = 0;
        do begin
            @(negedge clk);
            tmr_evt  = 3'b000;
            start_wr = 1'b0;
            lat++;
        end while (!track_hold && lat < 20);
        chk("R3 trigger latency", lat, exp_lat);
        if (src == 7) chk("R8 start flag set while busy", int'(start_flag), 1);
        trk = 0;
        while (track_hold && trk < 300) begin
            trk++;
            @(negedge clk);
        end
        chk("R4 track interval", trk, exp_trk);
        sar = 0;
        while (sar_active && sar < 300) begin
            sar++;
            @(negedge clk);
        end
        chk("R5 SAR phase length", sar, 13);
        chk("R6 done pulse after SAR", int'(done), 1);
        chk("R6 busy low at done", int'(busy), 0);
        if (src == 7) chk("R8 start flag cleared at done", int'(start_flag), 0);
        @(negedge clk);
        chk("R6 done lasts one cycle", int'(done), 0);
        src_sel = 3'b011;
    endtask

    task automatic run_cont(input int shdn, input int gain, input int exp_per, input int exp_trk);
        int rise_t[3];
        int rises, trk, hi;
        logic prev, overlap;
        src_sel    = 3'b011;
        auto_shdn  = shdn[0];
        gain_unity = gain[0];
        idle_cycles(3);
        src_sel = 3'b110;
        rises = 0;
        prev = 1'b0;
        overlap = 1'b0;
        trk = 0;
        for (int i = 0; i < 400 && rises < 3; i++) begin
            @(negedge clk);
            if (track_hold && !prev) begin
                rise_t[rises] = cyc;
                rises++;
            end
            if (rises == 1 && track_hold) trk++;
            if (done && track_hold) overlap = 1'b1;
            prev = track_hold;
        end
        chk("R9 continuous starts seen", rises, 3);
        chk("R9 continuous track interval", trk, exp_trk);
        chk("R9 continuous period a", rise_t[1] - rise_t[0], exp_per);
        chk("R9 continuous period b", rise_t[2] - rise_t[1], exp_per);
        chk("R9 done meets next track", int'(overlap), 1);
        // leave continuous mode in the middle of a conversion
        src_sel = 3'b000;
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        chk("R10 conversion finished after leaving 110", int'(done), 1);
        count_busy(70, hi);
        chk("R10 no restart after leaving 110", hi, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int hi;
        idle_cycles(2);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset track_hold", int'(track_hold), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset outputs", int'({track_hold, sar_active, busy, done, start_flag}), 0);

        for (int v = 0; v < VEC_N; v++) begin
            run_conv(V_SRC[v], V_SHDN[v], V_GAIN[v], V_LAT[v], V_TRK[v]);
        end

        // R2: reserved code with every event applied
        src_sel = 3'b011;
        idle_cycles(2);
        tmr_evt = 3'b111;
        start_wr = 1'b1;
        cnv_pin = 1'b1;
        @(negedge clk);
        tmr_evt = 3'b000;
        start_wr = 1'b0;
        count_busy(8, hi);
        chk("R2 reserved code starts nothing", hi, 0);
        cnv_pin = 1'b0;
        idle_cycles(4);

        // R2: event for another source
        src_sel = 3'b000;
        @(negedge clk);
        tmr_evt = 3'b110;
        start_wr = 1'b1;
        @(negedge clk);
        tmr_evt = 3'b000;
        start_wr = 1'b0;
        count_busy(6, hi);
        chk("R2 foreign event ignored", hi, 0);

        // R7: second trigger during busy
        src_sel = 3'b111;
        auto_shdn = 1'b0;
        gain_unity = 1'b0;
        @(negedge clk);
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        hi = 1;
        idle_cycles(9);
        hi += 9;
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        hi++;
        for (int i = 0; i < 200 && busy; i++) begin
            @(negedge clk);
            if (busy) hi++;
        end
        chk("R7 busy span of one conversion", hi, 56);
        begin
            int extra;
            count_busy(20, extra);
            chk("R7 trigger during busy ignored", extra, 0);
        end

        // R11: dual mode blocks software and continuous starts
        dual_mode = 1'b1;
        src_sel = 3'b111;
        @(negedge clk);
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        count_busy(5, hi);
        chk("R11 dual mode blocks software start", hi, 0);
        src_sel = 3'b110;
        count_busy(10, hi);
        chk("R11 dual mode blocks continuous", hi, 0);
        src_sel = 3'b011;
        dual_mode = 1'b0;
        idle_cycles(2);

        // R9/R10: continuous mode at both gains, auto_shdn has no effect there
        run_cont(1, 1, 16, 3);
        run_cont(0, 0, 56, 43);

        finish_run();
    end

endmodule